// File: doc/BRIEF.md
# Battery Status Check Sequencer

This block runs a one-shot check of the backup battery behind a battery-backed static RAM. Such a memory throws away the first write it sees after power returns when its battery has run low, and afterwards behaves normally. The sequencer uses that behaviour to find out the battery state. It reads one byte at a chosen address and writes the bitwise complement of that byte back to the same address. It then reads the address again. If the second read returns the complement, the write was accepted, so the battery is good, and the sequencer writes the original byte back. If the second read does not return the complement, the write was discarded. The block then reports a low battery and does no restore write, because the stored byte never changed.

System boot logic pulses `start` once after power-up. The sequencer has no other state: it drives a request port with a request/acknowledge handshake toward the memory controller. It raises `done` for one cycle when it finishes. Its two result flags stay valid until the next `start`.

Top module: `batt_check_seq`

## Requirements
- R1: After reset, `mem_req`, `done`, `battery_ok` and `battery_low` are all 0.
- R2: On an accepted `start`, the block captures `test_addr`. Every memory access of that run uses the captured address, even if `test_addr` changes later.
- R3: The first access of a run is a read (`mem_we`=0). The second access is a write (`mem_we`=1) whose data is the bitwise inversion of the value returned by the first read.
- R4: The third access is a read of the same address.
- R5: If the third access returns the inverted value, a fourth access writes the original value back. The run then ends with `battery_ok`=1 and `battery_low`=0.
- R6: If the third access returns any other value, no fourth access is issued. The run ends with `battery_low`=1 and `battery_ok`=0.
- R7: `done` is high for exactly one cycle per run. It rises in the cycle after the acknowledge of the last access. The result flags hold from that cycle until the next accepted `start`, which clears both of them.
- R8: A `start` that arrives while a run is in progress has no effect.
- R9: A request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high. `mem_rdata` is sampled in that cycle.
- R10: `battery_ok` and `battery_low` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; honoured only when idle |
| test_addr | input | ADDR_W | Address of the byte to probe |
| mem_req | output | 1 | Access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| battery_ok | output | 1 | Last run found the battery good |
| battery_low | output | 1 | Last run found the battery low |

## Verification
The bench builds the block with ADDR_W=5 and DATA_W=4. With these widths a short random run covers every byte value, including all-zeros and all-ones, where the inverted value is the other extreme. It also covers every address of a small modelled array. The memory model acknowledges after a random delay of zero to two cycles, which exercises the hold rule. It can be armed to discard the first write, so both verdicts occur. Directed cases move `test_addr` and pulse `start` again in the middle of a run.

// File: rtl/batt_check_seq.sv
module batt_check_seq #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] test_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              battery_ok,
  output logic              battery_low
);

  typedef enum logic [2:0] {
    S_IDLE, S_PEEK, S_FLIP, S_VERIFY, S_RESTORE, S_FINISH
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] orig_q;
  logic              ok_q, low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      orig_q <= '0;
      ok_q   <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_q <= test_addr;
          ok_q   <= 1'b0;
          low_q  <= 1'b0;
          state  <= S_PEEK;
        end
        S_PEEK: if (mem_ack) begin
          orig_q <= mem_rdata;
          state  <= S_FLIP;
        end
        S_FLIP: if (mem_ack) state <= S_VERIFY;
        S_VERIFY: if (mem_ack) begin
          if (mem_rdata == ~orig_q) state <= S_RESTORE;
          else begin
            low_q <= 1'b1;
            state <= S_FINISH;
          end
        end
        S_RESTORE: if (mem_ack) begin
          ok_q  <= 1'b1;
          state <= S_FINISH;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign mem_req     = (state == S_PEEK) || (state == S_FLIP) ||
                       (state == S_VERIFY) || (state == S_RESTORE);
  assign mem_we      = (state == S_FLIP) || (state == S_RESTORE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = (state == S_FLIP) ? ~orig_q : orig_q;
  assign done        = (state == S_FINISH);
  assign battery_ok  = ok_q;
  assign battery_low = low_q;

endmodule

// File: rtl/batt_check_seq_chk.sv
module batt_check_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              done,
  input logic              battery_ok,
  input logic              battery_low
);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) &&
                            $stable(mem_addr) && $stable(mem_wdata));

  assert_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> $stable(mem_addr));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (battery_ok != battery_low));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(battery_ok && battery_low));

  assert_no_req_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

endmodule

bind batt_check_seq batt_check_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .done(done), .battery_ok(battery_ok), .battery_low(battery_low)
);

// File: tb/batt_check_seq_test.sv
module batt_check_seq_test;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] test_addr = '0;
  logic mem_req, mem_we, mem_ack, done, battery_ok, battery_low;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  batt_check_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_addr(test_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .battery_ok(battery_ok), .battery_low(battery_low)
  );

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] mem [DEPTH];
  logic          pre_en = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic          pre_block = 1'b0;
  logic          block_armed;
  int            dly;
  int            log_n;
  int            done_n;
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      block_armed <= 1'b0;
      dly <= 0;
      log_n <= 0;
      done_n <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (done) done_n <= done_n + 1;
      if (pre_en) begin
        mem[pre_addr] <= pre_data;
        block_armed <= pre_block;
      end else if (mem_req && !mem_ack) begin
        if (dly > 0) dly <= dly - 1;
        else begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            if (block_armed) block_armed <= 1'b0;
            else mem[mem_addr] <= mem_wdata;
          end else mem_rdata <= mem[mem_addr];
          log_we[log_n % 64]   <= mem_we;
          log_addr[log_n % 64] <= mem_addr;
          log_data[log_n % 64] <= mem_we ? mem_wdata : mem[mem_addr];
          log_n <= log_n + 1;
          dly <= int'($urandom % 3);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_accesses(input bit low);
    return low ? 3 : 4;
  endfunction

  function automatic logic [DW-1:0] exp_access_data(input int idx, input logic [DW-1:0] v, input bit low);
    case (idx)
      0: return v;
      1: return ~v;
      2: return low ? v : ~v;
      default: return v;
    endcase
  endfunction

  task automatic run_trial(input logic [AW-1:0] a, input logic [DW-1:0] v,
                           input bit low, input bit disturb);
    int base, dn, cyc;
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a; pre_data = v; pre_block = low;
    @(negedge clk);
    pre_en = 1'b0;
    base = log_n; dn = done_n;
    start = 1'b1; test_addr = a;
    @(negedge clk);
    start = 1'b0;
    test_addr = a + AW'(1 + ($urandom % (DEPTH - 1)));
    check(!battery_ok && !battery_low, "R7 clear on start", int'(battery_ok) + int'(battery_low), 0);
    cyc = 0;
    while (!done && cyc < 100) begin
      if (disturb && cyc == 2) begin
        start = 1'b1;
        test_addr = ~a;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done, "R7 done seen", int'(done), 1);
    check(log_n - base == exp_accesses(low), low ? "R6 access count" : "R5 access count",
          log_n - base, exp_accesses(low));
    for (int i = 0; i < exp_accesses(low) && i < log_n - base; i++) begin
      int k = (base + i) % 64;
      check(log_addr[k] == a, "R2 access address", int'(log_addr[k]), int'(a));
      check(log_we[k] == (i == 1 || i == 3), i == 1 ? "R3 access kind" : "R4 access kind",
            int'(log_we[k]), int'(i == 1 || i == 3));
      check(log_data[k] == exp_access_data(i, v, low), i < 2 ? "R3 access data" : "R5 access data",
            int'(log_data[k]), int'(exp_access_data(i, v, low)));
    end
    check(battery_ok == !low, low ? "R6 ok flag" : "R5 ok flag", int'(battery_ok), int'(!low));
    check(battery_low == low, low ? "R6 low flag" : "R5 low flag", int'(battery_low), int'(low));
    check(mem[a] == v, "R5 data preserved", int'(mem[a]), int'(v));
    @(negedge clk);
    check(!done, "R7 single pulse", int'(done), 0);
    repeat (3) @(negedge clk);
    check(done_n - dn == 1, disturb ? "R8 one run only" : "R7 one done", done_n - dn, 1);
    check(battery_ok == !low && battery_low == low, "R7 flags held",
          int'({battery_ok, battery_low}), int'({!low, low}));
    check(!mem_req, "R8 idle after run", int'(mem_req), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!mem_req && !done && !battery_ok && !battery_low, "R1 reset state",
          int'({mem_req, done, battery_ok, battery_low}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !done && !battery_ok && !battery_low, "R1 idle after reset",
          int'({mem_req, done, battery_ok, battery_low}), 0);
    run_trial(5'd0, 4'h0, 1'b0, 1'b0);
    run_trial(5'd31, 4'hF, 1'b0, 1'b0);
    run_trial(5'd7, 4'hA, 1'b1, 1'b0);
    run_trial(5'd12, 4'h5, 1'b0, 1'b1);
    run_trial(5'd19, 4'h3, 1'b1, 1'b1);
    for (int t = 0; t < 60; t++)
      run_trial(AW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule